// File: doc/BRIEF.md
# Lockable One-Time Protection Register

This block is a 128-bit security register that sits next to a flash command decoder. The register holds eight 16-bit words in two halves. The lower half is a unique value fixed at build time through a parameter, and no command can change it. The upper half belongs to the user. Each program operation can only clear bits in it, the way flash cells behave. A lock command freezes the upper half permanently.

All access goes over a simple bus with an address, a write data word, a write strobe and a read strobe. Each strobe lasts one clock and counts as one bus cycle. Commands begin with a two-write unlock prefix (0x555/0xAA, then 0x2AA/0x55), followed by a command byte written to 0x555. The command byte is compared on data bits 7:0 only.

- Command 0x90 enters identification mode.
- Command 0xF0 leaves identification mode.
- Command 0xC0 takes one more write, which programs a user word.
- Command 0x60 takes one more write, which locks the user half when its data bit 0 is 1.

The register can only be read while identification mode is active. Program and lock commands are refused until the mode is exited.

Top module: `otp_prot_reg`

## Requirements
- R1: During and after synchronous reset, identification mode is off and rd_data is 0. All 64 user bits read as 1 and the lock flag reads 0.
- R2: Writes 0x555/0xAA, then 0x2AA/0x55, then 0x555 with 0x90 turn identification mode on once the third write completes. The same prefix followed by 0x555/0xF0 turns it off.
- R3: In identification mode, a read returns the following word, and any other address reads 0:
  - address 0x000 returns the manufacturer code;
  - address 0x001 returns the device code;
  - address 0x080 returns the lock flag in bit 1, with all other bits 0;
  - addresses 0x081 to 0x084 return fixed words 0 to 3, where word k is bits 16k+15 down to 16k of the factory value;
  - addresses 0x085 to 0x088 return user words 0 to 3.
- R4: rd_data is loaded on the clock edge that samples the read strobe and holds its value in every other cycle.
- R5: When identification mode is off, a read returns 0.
- R6: The prefix, then 0x555/0xC0, then a fourth write at an address from 0x085 to 0x088 replaces that user word with its old value AND the written data. Bits can only go from 1 to 0.
- R7: A program write aimed at 0x081–0x084 or at any address outside 0x085–0x088 changes no word. The fixed half never changes.
- R8: The prefix, then 0x555/0x60, then a fourth write whose data bit 0 is 1 sets the lock flag. If bit 0 is 0, no lock is set. The other data bits and the address of that write have no effect.
- R9: Once the lock flag is set, it stays set until reset, and every program command leaves the user words unchanged.
- R10: While identification mode is on, program and lock commands change neither the user words nor the lock flag.
- R11: A write in a prefix cycle with a wrong address or data value returns the decoder to idle with no effect. The next write is then decoded as a first prefix cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one bus cycle per asserted clock |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Bus address / register offset |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| id_active | output | 1 | Identification mode is on |

## Verification
The bench targets the following corner cases and what a faulty design would do in each:

- **Lock with data bit 0 clear.** A decoder that ignored the bit would lock anyway, and the lock status read would show it.
- **Programming after a lock.** A store that did not gate on the lock flag would change a user word that has to stay frozen.
- **Repeated programs of the same word.** A design that overwrote instead of clearing bits would bring back 1s that had already been cleared.
- **Program aimed at the fixed half or out of range.** An off-by-one in offset decoding would corrupt a neighbouring word.
- **Program or lock issued in identification mode.** A design that accepted them would modify state it should have refused.
- **Bad second prefix write followed at once by a full sequence.** A decoder that did not return to idle would misinterpret the following writes.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

    localparam int WORD_W    = 16;
    localparam int BLK_WORDS = 4;
    localparam int BLK_BITS  = WORD_W * BLK_WORDS;
    localparam int IDX_W     = $clog2(BLK_WORDS);

    // unlock prefix and command codes (low data byte)
    localparam int UNLK_ADDR1 = 'h555;
    localparam int UNLK_ADDR2 = 'h2AA;
    localparam logic [7:0] UNLK_KEY1 = 8'hAA;
    localparam logic [7:0] UNLK_KEY2 = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'hC0;
    localparam logic [7:0] OP_LOCK   = 8'h60;
    localparam logic [7:0] OP_ID_IN  = 8'h90;
    localparam logic [7:0] OP_ID_OUT = 8'hF0;

    // register offsets in identification space
    localparam int OFF_MFR   = 'h000;
    localparam int OFF_DEV   = 'h001;
    localparam int OFF_STAT  = 'h080;
    localparam int OFF_FIXED = 'h081;
    localparam int OFF_USER  = OFF_FIXED + BLK_WORDS;
    localparam int STAT_LOCK_BIT = 1;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_PROG,
        SEQ_LOCK
    } seq_st_e;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } prog_req_t;

    function automatic logic in_window(input int a, input int base);
        return (a >= base) && (a < base + BLK_WORDS);
    endfunction

    function automatic logic [IDX_W-1:0] win_idx(input int a, input int base);
        return IDX_W'(a - base);
    endfunction

endpackage

// File: rtl/otp_cmd_seq.sv
`timescale 1ns/1ps
module otp_cmd_seq
    import otp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output prog_req_t           prog,
    output logic                lock_req,
    output logic                id_mode
);

    seq_st_e st_q, st_d;
    logic    id_d;
    int      a_int;

    assign a_int = int'(addr);

    always_comb begin
        st_d     = st_q;
        id_d     = id_mode;
        prog     = '0;
        lock_req = 1'b0;
        if (wr_stb) begin
            st_d = SEQ_IDLE;
            unique case (st_q)
                SEQ_IDLE: begin
                    if (a_int == UNLK_ADDR1 && wdata[7:0] == UNLK_KEY1)
                        st_d = SEQ_KEY1;
                end
                SEQ_KEY1: begin
                    if (a_int == UNLK_ADDR2 && wdata[7:0] == UNLK_KEY2)
                        st_d = SEQ_KEY2;
                end
                SEQ_KEY2: begin
                    if (a_int == UNLK_ADDR1) begin
                        if (wdata[7:0] == OP_ID_IN)
                            id_d = 1'b1;
                        else if (wdata[7:0] == OP_ID_OUT)
                            id_d = 1'b0;
                        else if (wdata[7:0] == OP_PROG && !id_mode)
                            st_d = SEQ_PROG;
                        else if (wdata[7:0] == OP_LOCK && !id_mode)
                            st_d = SEQ_LOCK;
                    end
                end
                SEQ_PROG: begin
                    if (in_window(a_int, OFF_USER)) begin
                        prog.vld  = 1'b1;
                        prog.idx  = win_idx(a_int, OFF_USER);
                        prog.data = wdata;
                    end
                end
                SEQ_LOCK: begin
                    lock_req = wdata[0];
                end
                default: st_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            st_q    <= st_d;
            id_mode <= id_d;
        end
    end

endmodule

// File: rtl/otp_user_blk.sv
`timescale 1ns/1ps
module otp_user_blk
    import otp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  prog_req_t           prog,
    input  logic                lock_req,
    output logic [BLK_BITS-1:0] user_bits,
    output logic                locked
);

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (lock_req)
            locked <= 1'b1;
    end

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '1;
            else if (prog.vld && !locked && prog.idx == IDX_W'(g))
                word_q <= word_q & prog.data;
        end
        assign user_bits[g*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/otp_read_port.sv
`timescale 1ns/1ps
module otp_read_port
    import otp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                id_mode,
    input  logic [BLK_BITS-1:0] fixed_bits,
    input  logic [BLK_BITS-1:0] user_bits,
    input  logic                locked,
    input  logic [WORD_W-1:0]   mfr_code,
    input  logic [WORD_W-1:0]   dev_code,
    output logic [WORD_W-1:0]   rd_data
);

    logic [WORD_W-1:0] word;
    int                a_int;

    assign a_int = int'(addr);

    always_comb begin
        word = '0;
        if (id_mode) begin
            if (a_int == OFF_MFR)
                word = mfr_code;
            else if (a_int == OFF_DEV)
                word = dev_code;
            else if (a_int == OFF_STAT)
                word[STAT_LOCK_BIT] = locked;
            else if (in_window(a_int, OFF_FIXED))
                word = fixed_bits[win_idx(a_int, OFF_FIXED)*WORD_W +: WORD_W];
            else if (in_window(a_int, OFF_USER))
                word = user_bits[win_idx(a_int, OFF_USER)*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= word;
    end

endmodule

// File: rtl/otp_prot_reg.sv
`timescale 1ns/1ps
module otp_prot_reg
    import otp_pkg::*;
#(
    parameter int                  ADDR_W     = 12,
    parameter logic [BLK_BITS-1:0] FACTORY_ID = 64'h5A3C_91E7_0D42_B86F,
    parameter logic [WORD_W-1:0]   MFR_CODE   = 16'h003D,
    parameter logic [WORD_W-1:0]   DEV_CODE   = 16'h22C7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              id_active
);

    prog_req_t           prog_req;
    logic                lock_req;
    logic                lock_q;
    logic                prog_vld;
    logic [BLK_BITS-1:0] user_bits;

    assign prog_vld = prog_req.vld;

    otp_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .prog     (prog_req),
        .lock_req (lock_req),
        .id_mode  (id_active)
    );

    otp_user_blk u_user (
        .clk       (clk),
        .rst       (rst),
        .prog      (prog_req),
        .lock_req  (lock_req),
        .user_bits (user_bits),
        .locked    (lock_q)
    );

    otp_read_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_stb     (bus_rd),
        .addr       (bus_addr),
        .id_mode    (id_active),
        .fixed_bits (FACTORY_ID),
        .user_bits  (user_bits),
        .locked     (lock_q),
        .mfr_code   (MFR_CODE),
        .dev_code   (DEV_CODE),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/otp_prot_reg_chk.sv
`timescale 1ns/1ps
module otp_prot_reg_chk
    import otp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_rd,
    input logic [WORD_W-1:0]   rd_data,
    input logic                id_mode,
    input logic                locked,
    input logic [BLK_BITS-1:0] user_bits
);

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R9
    locked_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(user_bits));

    // R6
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~$past(user_bits) & user_bits) == '0));

    // R10
    id_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        id_mode |=> ($stable(user_bits) && $stable(locked)));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(rd_data));

    // R5
    rd_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !id_mode) |=> (rd_data == '0));

endmodule

bind otp_prot_reg otp_prot_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .rd_data   (rd_data),
    .id_mode   (id_active),
    .locked    (lock_q),
    .user_bits (user_bits)
);

// File: tb/sim_otp_prot_reg.sv
`timescale 1ns/1ps
module sim_otp_prot_reg;

    localparam logic [63:0] FID = 64'h5A3C_91E7_0D42_B86F;
    localparam logic [15:0] MFR = 16'h003D;
    localparam logic [15:0] DEV = 16'h22C7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic        id_active;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // bench model
    bit          m_id;
    bit          m_lock;
    logic [15:0] m_b [4];

    always #2.5 clk = ~clk;

    otp_prot_reg u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .id_active(id_active)
    );

    function automatic logic [15:0] exp_rd(input logic [11:0] a);
        if (!m_id) return 16'h0;
        if (a == 12'h000) return MFR;
        if (a == 12'h001) return DEV;
        if (a == 12'h080) return {14'h0, m_lock, 1'b0};
        if (a >= 12'h081 && a <= 12'h084) return FID[(a - 12'h081)*16 +: 16];
        if (a >= 12'h085 && a <= 12'h088) return m_b[a - 12'h085];
        return 16'h0;
    endfunction

    task automatic ck(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 0; bus_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_id = 0; m_lock = 0;
        for (int i = 0; i < 4; i++) m_b[i] = 16'hFFFF;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        ck(req, rd_data, exp_rd(a));
    endtask

    task automatic cmd3(input logic [7:0] op);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, {8'h00, op});
        if (op == 8'h90) m_id = 1;
        if (op == 8'hF0) m_id = 0;
    endtask

    task automatic prog(input logic [11:0] a, input logic [15:0] d);
        cmd3(8'hC0);
        wr(a, d);
        if (!m_id && !m_lock && a >= 12'h085 && a <= 12'h088)
            m_b[a - 12'h085] &= d;
    endtask

    task automatic lock(input logic [11:0] a, input logic [15:0] d);
        cmd3(8'h60);
        wr(a, d);
        if (!m_id && d[0]) m_lock = 1;
    endtask

    task automatic dump_all(input string req);
        bit was = m_id;
        if (!was) cmd3(8'h90);
        rd_chk(12'h080, req);
        for (int i = 12'h081; i <= 12'h088; i++) rd_chk(12'(i), req);
        if (!was) cmd3(8'hF0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        do_reset();
        // R1 reset state
        ck("R1 id", {15'h0, id_active}, 16'h0);
        ck("R1 rd", rd_data, 16'h0);
        // R2 entry
        cmd3(8'h90);
        ck("R2 entry", {15'h0, id_active}, 16'h1);
        // R3 ID codes and fixed half, R1 user erased and unlocked
        rd_chk(12'h000, "R3 mfr");
        rd_chk(12'h001, "R3 dev");
        rd_chk(12'h089, "R3 unused");
        dump_all("R1 R3 initial");
        // R4 hold: no strobe, rd_data must keep last value
        @(negedge clk); bus_addr = 12'h000;
        repeat (3) @(negedge clk);
        ck("R4 hold", rd_data, exp_rd(12'h088));
        // R10 program and lock refused in ID mode
        prog(12'h085, 16'h0000);
        lock(12'h000, 16'h0001);
        dump_all("R10 id refuse");
        cmd3(8'hF0);
        ck("R2 exit", {15'h0, id_active}, 16'h0);
        // R5 closed read
        rd_chk(12'h081, "R5 closed");
        // R6 bit clearing, repeated programs
        prog(12'h086, 16'h0F0F);
        prog(12'h086, 16'hFF00);
        prog(12'h088, 16'h1234);
        // R7 fixed half and out-of-range
        prog(12'h081, 16'h0000);
        prog(12'h084, 16'h0000);
        prog(12'h089, 16'h0000);
        dump_all("R6 R7 program");
        // R11 bad prefix then full sequence
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0054);
        prog(12'h085, 16'hAAAA);
        wr(12'h556, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h00C0);
        wr(12'h087, 16'h0000);
        dump_all("R11 bad prefix");
        // R8 lock with bit0 clear has no effect
        lock(12'h3FF, 16'hFFFE);
        dump_all("R8 bit0 clear");
        // R8 lock with bit0 set, other bits arbitrary
        lock(12'h123, 16'h8001);
        dump_all("R8 lock set");
        // R9 program after lock ignored, lock sticks
        prog(12'h087, 16'h0000);
        prog(12'h085, 16'h0000);
        lock(12'h000, 16'h0000);
        dump_all("R9 locked");
        do_reset();
        dump_all("R1 after reset");

        // constrained random phase
        for (int it = 0; it < 400; it++) begin
            int r;
            if (it == 200) do_reset();
            r = int'($urandom % 10);
            case (r)
                0, 1, 2, 3: prog(12'h080 + 12'($urandom % 11), 16'($urandom));
                4: lock(12'($urandom), ($urandom % 8 == 0) ? 16'($urandom) | 16'h1
                                                           : 16'($urandom) & 16'hFFFE);
                5: cmd3(8'h90);
                6: cmd3(8'hF0);
                7, 8: begin
                    int k = int'($urandom % 12);
                    rd_chk(k < 2 ? 12'(k) : 12'h07E + 12'(k), "R3 R5 random read");
                end
                default: begin
                    wr(12'h555, 16'h00AA);
                    wr(12'h2AA, 16'h005A);
                end
            endcase
            ck("R2 R10 random id", {15'h0, id_active}, {15'h0, m_id});
        end
        dump_all("R6 R9 random final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule